// File: doc/BRIEF.md
# Reconfigurable Precision Booth Multiply-Accumulate Unit

This block is a signed multiply-accumulate engine for convolution inner loops. Its datapath is sized for 4-bit operands. The same hardware can also serve narrower and wider operands. Each cycle it takes two packed 16-bit words: a multiplicand word and a multiplier word. It multiplies the signed lanes of the two words pairwise and adds each product to its own running sum. The lane width is chosen by a precision code:

| Precision | Products per cycle |
|-----------|--------------------|
| 2-bit     | eight              |
| 4-bit     | four               |
| 8-bit     | two                |

The multiplier word is recoded into radix-4 Booth digits, each taking a value in {-2,-1,0,+1,+2}. One digit covers two multiplier bits, and every precision uses the same eight digit slices. The digits of a 4-bit slice form one base product. An 8-bit product joins two adjacent base products, the upper one weighted by 16. A 2-bit product uses a single digit on its own. Sign extension and carries never cross a lane boundary.

A product register sits after the reduction. The accumulators add its contents on the following edge. A clear strobe starts a new sum: the accumulator loads the incoming product instead of adding it. The precision code is taken in only together with a clear, so it cannot change in the middle of a sum.

Top module: `mixprec_booth_mac`

## Requirements
- R1: While rst_n is low and after its release, all eight accumulator slots read zero and the latched precision is 4-bit.
- R2: Precision codes on mode_i are 0 for 2-bit, 1 for 4-bit and 2 for 8-bit; code 3 behaves as 4-bit. Lane k of width w occupies bits [w*k+w-1 : w*k] of a_i and of b_i. Its product goes to slot k. Slot k of acc_o is bits [24*k+23 : 24*k].
- R3: In 2-bit precision, every slot 0..7 receives the signed product of its 2-bit lanes, for all operand values.
- R4: In 4-bit precision, slots 0..3 receive the signed products of the 4-bit lanes, for all operand values. A clear in this precision leaves slots 4..7 at zero.
- R5: In 8-bit precision, slots 0..1 receive the signed products of the byte lanes, including -128 times -128. A clear in this precision leaves slots 2..7 at zero.
- R6: A product depends only on its own lanes. Sign bits and carries of one lane never change a neighbouring slot.
- R7: valid_i with clear_i loads each slot with its product. valid_i without clear_i adds the product to the slot.
- R8: Each slot is 24 bits wide and wraps modulo 2^24 on overflow.
- R9: An operand pair sampled at a rising edge with valid_i high changes acc_o at the second rising edge. Back-to-back valid cycles are all taken. Without valid_i, acc_o holds.
- R10: mode_i is latched only when valid_i and clear_i are both high. It is ignored when valid_i is high without clear_i, and that cycle computes with the latched precision.
- R11: Results are exact for every multiplier value, including the most negative value of each width. This holds because each Booth slice takes the bit below it from the same lane, and the lowest slice of a lane takes zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; deassertion must be synchronous to clk |
| mode_i | input | 2 | Precision code: 0 = 2-bit, 1 = 4-bit, 2 = 8-bit, 3 = 4-bit |
| a_i | input | 16 | Packed signed multiplicand lanes |
| b_i | input | 16 | Packed signed multiplier lanes, Booth recoded |
| valid_i | input | 1 | Operand words are valid this cycle |
| clear_i | input | 1 | With valid_i: restart the sums and latch mode_i |
| acc_o | output | 192 | Eight 24-bit signed accumulator slots, slot 0 in the low bits |

## Verification
A wrong Booth digit or a wrong below-bit selection shows up in the affected slot at the second edge after the operands enter. It appears only for some multiplier values, so every lane width gets an exhaustive multiplier sweep against an integer model. A lane boundary leak shows up as a neighbouring slot off by a power of two, and extreme negative operands in adjacent lanes expose it. A wrongly latched precision or a lost clear corrupts every later sum until the next clear. Sequences that change mode_i without a clear, and long accumulation runs that wrap, therefore show such errors at once and keep showing them.

// File: rtl/mpm_pkg.sv
package mpm_pkg;

  typedef enum logic [1:0] {
    PREC_W2  = 2'd0,
    PREC_W4  = 2'd1,
    PREC_W8  = 2'd2,
    PREC_RSV = 2'd3
  } prec_e;

  // Radix-4 Booth digit: value = (neg ? -1 : 1) * (two ? 2 : one ? 1 : 0)
  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } bdig_t;

  function automatic prec_e prec_norm(input logic [1:0] code);
    prec_e r;
    unique case (code)
      2'd0:    r = PREC_W2;
      2'd2:    r = PREC_W8;
      default: r = PREC_W4;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/mpm_booth_enc.sv
module mpm_booth_enc
  import mpm_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int NDIG = WORD_W / 2
) (
  input  prec_e                  prec,
  input  logic [WORD_W-1:0]      mult,
  output bdig_t [NDIG-1:0]       dig
);

  for (genvar j = 0; j < NDIG; j++) begin : g_dig
    logic below;
    logic hi, mid;

    if (j == 0) begin : g_first
      assign below = 1'b0;
    end else begin : g_rest
      // lowest slice of every lane sees an implicit zero
      localparam bit START8 = ((j % 4) == 0);
      localparam bit START4 = ((j % 2) == 0);
      always_comb begin
        unique case (prec)
          PREC_W2: below = 1'b0;
          PREC_W8: below = START8 ? 1'b0 : mult[2*j-1];
          default: below = START4 ? 1'b0 : mult[2*j-1];
        endcase
      end
    end

    assign hi  = mult[2*j+1];
    assign mid = mult[2*j];

    always_comb begin
      dig[j].neg = hi & ~(mid & below);
      dig[j].one = mid ^ below;
      dig[j].two = (hi & ~mid & ~below) | (~hi & mid & below);
    end
  end

endmodule

// File: rtl/mpm_ppgen.sv
module mpm_ppgen
  import mpm_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int NDIG = WORD_W / 2,
  localparam int PP_W = 10
) (
  input  prec_e                         prec,
  input  logic [WORD_W-1:0]             mcand,
  input  bdig_t [NDIG-1:0]              dig,
  output logic [NDIG-1:0][PP_W-1:0]     pp
);

  for (genvar j = 0; j < NDIG; j++) begin : g_pp
    localparam int L2 = 2 * j;
    localparam int L4 = 4 * (j / 2);
    localparam int L8 = 8 * (j / 4);

    logic signed [PP_W-1:0] mc;
    logic signed [PP_W-1:0] mag;

    // sign-extend the multiplicand lane this digit belongs to
    always_comb begin
      unique case (prec)
        PREC_W2: mc = {{(PP_W-2){mcand[L2+1]}}, mcand[L2 +: 2]};
        PREC_W8: mc = {{(PP_W-8){mcand[L8+7]}}, mcand[L8 +: 8]};
        default: mc = {{(PP_W-4){mcand[L4+3]}}, mcand[L4 +: 4]};
      endcase
    end

    always_comb begin
      if (dig[j].two)      mag = mc <<< 1;
      else if (dig[j].one) mag = mc;
      else                 mag = '0;
      pp[j] = dig[j].neg ? -mag : mag;
    end
  end

endmodule

// File: rtl/mpm_combine.sv
module mpm_combine
  import mpm_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int PROD_W = 16,
  localparam int NDIG  = WORD_W / 2,
  localparam int NSLOT = WORD_W / 2,
  localparam int NNIB  = WORD_W / 4,
  localparam int NBYTE = WORD_W / 8,
  localparam int PP_W  = 10
) (
  input  prec_e                          prec,
  input  logic [NDIG-1:0][PP_W-1:0]      pp,
  output logic [NSLOT-1:0][PROD_W-1:0]   prod
);

  logic [NDIG-1:0][PROD_W-1:0]  ppx;
  logic [NNIB-1:0][PROD_W-1:0]  nib;
  logic [NBYTE-1:0][PROD_W-1:0] byt;

  for (genvar j = 0; j < NDIG; j++) begin : g_ext
    assign ppx[j] = {{(PROD_W-PP_W){pp[j][PP_W-1]}}, pp[j]};
  end

  // 4-bit base product: two digits, upper one weighted by 4
  for (genvar m = 0; m < NNIB; m++) begin : g_nib
    assign nib[m] = ppx[2*m] + (ppx[2*m+1] << 2);
  end

  // 8-bit product: two base products, upper one weighted by 16
  for (genvar n = 0; n < NBYTE; n++) begin : g_byte
    assign byt[n] = nib[2*n] + (nib[2*n+1] << 4);
  end

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    logic [PROD_W-1:0] v4, v8;
    if (k < NNIB) begin : g_v4
      assign v4 = nib[k];
    end else begin : g_z4
      assign v4 = '0;
    end
    if (k < NBYTE) begin : g_v8
      assign v8 = byt[k];
    end else begin : g_z8
      assign v8 = '0;
    end
    always_comb begin
      unique case (prec)
        PREC_W2: prod[k] = ppx[k];
        PREC_W8: prod[k] = v8;
        default: prod[k] = v4;
      endcase
    end
  end

endmodule

// File: rtl/mpm_accum.sv
module mpm_accum #(
  parameter int NSLOT  = 8,
  parameter int PROD_W = 16,
  parameter int ACC_W  = 24
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          en,
  input  logic                          load,
  input  logic [NSLOT-1:0][PROD_W-1:0]  prod,
  output logic [NSLOT-1:0][ACC_W-1:0]   acc
);

  logic [NSLOT-1:0][ACC_W-1:0] acc_q, acc_d;

  always_comb begin
    for (int k = 0; k < NSLOT; k++) begin
      logic [ACC_W-1:0] ext;
      ext      = {{(ACC_W-PROD_W){prod[k][PROD_W-1]}}, prod[k]};
      acc_d[k] = load ? ext : acc_q[k] + ext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  acc_q <= '0;
    else if (en) acc_q <= acc_d;
  end

  assign acc = acc_q;

endmodule

// File: rtl/mixprec_booth_mac.sv
module mixprec_booth_mac
  import mpm_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ACC_W  = 24,
  localparam int NSLOT  = WORD_W / 2,
  localparam int NDIG   = WORD_W / 2,
  localparam int PROD_W = 16,
  localparam int PP_W   = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              mode_i,
  input  logic [WORD_W-1:0]       a_i,
  input  logic [WORD_W-1:0]       b_i,
  input  logic                    valid_i,
  input  logic                    clear_i,
  output logic [NSLOT*ACC_W-1:0]  acc_o
);

  prec_e mode_q, mode_d, prec_eff;

  bdig_t [NDIG-1:0]              dig;
  logic [NDIG-1:0][PP_W-1:0]     pp;
  logic [NSLOT-1:0][PROD_W-1:0]  prod_d, prod_q;
  logic                          vld_q, clr_q;
  logic [NSLOT-1:0][ACC_W-1:0]   acc;

  // precision used this cycle, and the latched precision
  always_comb begin
    prec_eff = clear_i ? prec_norm(mode_i) : mode_q;
    mode_d   = (valid_i && clear_i) ? prec_norm(mode_i) : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= PREC_W4;
    else        mode_q <= mode_d;
  end

  mpm_booth_enc #(.WORD_W(WORD_W)) enc_i (
    .prec (prec_eff),
    .mult (b_i),
    .dig  (dig)
  );

  mpm_ppgen #(.WORD_W(WORD_W)) ppg_i (
    .prec  (prec_eff),
    .mcand (a_i),
    .dig   (dig),
    .pp    (pp)
  );

  mpm_combine #(.WORD_W(WORD_W), .PROD_W(PROD_W)) cmb_i (
    .prec (prec_eff),
    .pp   (pp),
    .prod (prod_d)
  );

  // pipeline register after reduction
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      vld_q <= valid_i;
      clr_q <= valid_i & clear_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prod_q <= '0;
    else if (valid_i) prod_q <= prod_d;
  end

  mpm_accum #(.NSLOT(NSLOT), .PROD_W(PROD_W), .ACC_W(ACC_W)) acc_i (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (vld_q),
    .load  (clr_q),
    .prod  (prod_q),
    .acc   (acc)
  );

  assign acc_o = acc;

endmodule

// File: rtl/mpm_checker.sv
module mpm_checker #(
  parameter int WORD_W = 16,
  parameter int ACC_W  = 24,
  localparam int NSLOT = WORD_W / 2,
  localparam int NNIB  = WORD_W / 4,
  localparam int NBYTE = WORD_W / 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [1:0]              mode_i,
  input logic                    valid_i,
  input logic                    clear_i,
  input logic [NSLOT*ACC_W-1:0]  acc_o,
  input logic [1:0]              mode_q
);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(valid_i, 2) |-> $stable(acc_o));

  assert_mode_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_i && clear_i) |=> $stable(mode_q));

  assert_w8_spare_slots_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(valid_i && clear_i && mode_i == 2'd2, 2)
      |-> acc_o[NSLOT*ACC_W-1:NBYTE*ACC_W] == '0);

  assert_w4_spare_slots_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(valid_i && clear_i && (mode_i == 2'd1 || mode_i == 2'd3), 2)
      |-> acc_o[NSLOT*ACC_W-1:NNIB*ACC_W] == '0);

  for (genvar k = 0; k < NSLOT; k++) begin : g_w2
    assert_w2_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(valid_i && clear_i && mode_i == 2'd0, 2)
        |-> ($signed(acc_o[k*ACC_W +: ACC_W]) >= -2 &&
             $signed(acc_o[k*ACC_W +: ACC_W]) <= 4));
  end

endmodule

bind mixprec_booth_mac mpm_checker #(.WORD_W(WORD_W), .ACC_W(ACC_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .mode_i  (mode_i),
  .valid_i (valid_i),
  .clear_i (clear_i),
  .acc_o   (acc_o),
  .mode_q  (mode_q)
);

// File: tb/mixprec_booth_mac_tb_top.sv
module mixprec_booth_mac_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WORD_W = 16;
  localparam int ACC_W  = 24;
  localparam int NSLOT  = 8;

  typedef struct packed {
    logic [1:0]  m;
    logic        c;
    logic [15:0] a;
    logic [15:0] b;
  } vec_t;

  // stimulus table; expected sums come from the integer model below
  localparam int NVEC = 10;
  localparam vec_t VEC [NVEC] = '{
    '{2'd0, 1'b1, 16'h1B6C, 16'hE4D2},
    '{2'd0, 1'b0, 16'hAAAA, 16'h5555},
    '{2'd1, 1'b1, 16'h8F7A, 16'h8F7A},
    '{2'd1, 1'b0, 16'h1234, 16'hFEDC},
    '{2'd3, 1'b1, 16'hC3A5, 16'h7E81},
    '{2'd2, 1'b1, 16'h807F, 16'h8080},
    '{2'd2, 1'b0, 16'hFF01, 16'h7FFF},
    '{2'd0, 1'b1, 16'hFFFF, 16'hAAAA},
    '{2'd2, 1'b1, 16'h0080, 16'h8000},
    '{2'd1, 1'b1, 16'h0000, 16'h1111}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] mode_i;
  logic [WORD_W-1:0] a_i, b_i;
  logic valid_i, clear_i;
  logic [NSLOT*ACC_W-1:0] acc_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [ACC_W-1:0] exp_acc [NSLOT];
  logic [1:0] m_mode;

  always #(CLK_PERIOD/2) clk = ~clk;

  mixprec_booth_mac #(.WORD_W(WORD_W), .ACC_W(ACC_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .a_i(a_i), .b_i(b_i),
    .valid_i(valid_i), .clear_i(clear_i), .acc_o(acc_o)
  );

  function automatic int width_of(input logic [1:0] m);
    return (m == 2'd0) ? 2 : (m == 2'd2) ? 8 : 4;
  endfunction

  function automatic longint lane_val(input logic [15:0] w, input int bits, input int k);
    longint x;
    x = longint'(w >> (bits * k)) & ((longint'(1) << bits) - 1);
    if (x >= (longint'(1) << (bits - 1))) x -= (longint'(1) << bits);
    return x;
  endfunction

  task automatic model_op(input logic [1:0] m, input logic c,
                          input logic [15:0] a, input logic [15:0] b);
    logic [1:0] eff;
    int w;
    eff = c ? m : m_mode;
    if (c) m_mode = m;
    w = width_of(eff);
    for (int k = 0; k < NSLOT; k++) begin
      longint p;
      p = (k < 16 / w) ? lane_val(a, w, k) * lane_val(b, w, k) : 0;
      exp_acc[k] = (c ? '0 : exp_acc[k]) + ACC_W'(p);
    end
  endtask

  task automatic check_acc(input string req);
    bit bad = 1'b0;
    n_run++;
    for (int k = 0; k < NSLOT; k++) begin
      if (acc_o[k*ACC_W +: ACC_W] !== exp_acc[k]) begin
        $display("FAIL %s slot %0d: got %h expected %h", req, k,
                 acc_o[k*ACC_W +: ACC_W], exp_acc[k]);
        bad = 1'b1;
      end
    end
    if (bad) n_fail++;
  endtask

  task automatic do_op(input logic [1:0] m, input logic c,
                       input logic [15:0] a, input logic [15:0] b, input string req);
    @(negedge clk);
    mode_i = m; clear_i = c; a_i = a; b_i = b; valid_i = 1'b1;
    model_op(m, c, a, b);
    @(negedge clk);
    valid_i = 1'b0; clear_i = 1'b0;
    @(negedge clk);
    check_acc(req);
  endtask

  task automatic reset_model();
    for (int k = 0; k < NSLOT; k++) exp_acc[k] = '0;
    m_mode = 2'd1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; mode_i = 2'd0; a_i = '0; b_i = '0; valid_i = 1'b0; clear_i = 1'b0;
    reset_model();
    repeat (3) @(negedge clk);
    check_acc("R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_acc("R1 after reset");
    // R1: latched precision after reset is 4-bit, mode_i ignored without clear
    do_op(2'd0, 1'b0, 16'h7777, 16'h7777, "R1 reset precision");

    // table walk: R2 R3 R4 R5 R7
    for (int i = 0; i < NVEC; i++) begin
      string req;
      if (!VEC[i].c)            req = "R7 add";
      else if (VEC[i].m == 2'd0) req = "R3";
      else if (VEC[i].m == 2'd2) req = "R5";
      else if (VEC[i].m == 2'd3) req = "R2 code3";
      else                       req = "R4";
      do_op(VEC[i].m, VEC[i].c, VEC[i].a, VEC[i].b, req);
    end

    // R10: mode_i without clear is ignored
    do_op(2'd1, 1'b1, 16'h9C3E, 16'h5A87, "R10 setup");
    do_op(2'd2, 1'b0, 16'h8181, 16'h7F80, "R10 ignore 8b");
    do_op(2'd0, 1'b0, 16'hA5A5, 16'h3C3C, "R10 ignore 2b");

    // R6: extreme neighbouring lanes
    do_op(2'd0, 1'b1, 16'hAAAA, 16'hAAAA, "R6 2b all -2");
    do_op(2'd1, 1'b1, 16'h8F8F, 16'h8181, "R6 4b");
    do_op(2'd2, 1'b1, 16'h8080, 16'h80FF, "R6 8b");

    // R11 + R3: exhaustive 2-bit pairs, eight per operation
    for (int o = 0; o < 2; o++) begin
      logic [15:0] a, b;
      for (int l = 0; l < 8; l++) begin
        int idx;
        idx = o * 8 + l;
        a[2*l +: 2] = 2'(idx >> 2);
        b[2*l +: 2] = 2'(idx);
      end
      do_op(2'd0, 1'b1, a, b, "R11 2b sweep");
    end

    // R11 + R4: exhaustive 4-bit pairs, four per operation
    for (int o = 0; o < 64; o++) begin
      logic [15:0] a, b;
      for (int l = 0; l < 4; l++) begin
        int idx;
        idx = o * 4 + l;
        a[4*l +: 4] = 4'(idx >> 4);
        b[4*l +: 4] = 4'(idx);
      end
      do_op(2'd1, 1'b1, a, b, "R11 4b sweep");
    end

    // R11 + R5: every multiplier byte against a spread of multiplicands
    for (int ia = 0; ia < 17; ia++) begin
      for (int bv = 0; bv < 256; bv += 2) begin
        logic [7:0] av;
        av = (ia == 16) ? 8'h80 : 8'(ia * 17);
        do_op(2'd2, 1'b1, {~av, av}, {8'(bv + 1), 8'(bv)}, "R11 8b sweep");
      end
    end

    // R9: latency, sum unchanged after one edge, updated after two
    do_op(2'd1, 1'b1, 16'h1111, 16'h2222, "R9 base");
    @(negedge clk);
    mode_i = 2'd1; clear_i = 1'b0; a_i = 16'h3333; b_i = 16'h3333; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    check_acc("R9 one edge");
    model_op(2'd1, 1'b0, 16'h3333, 16'h3333);
    @(negedge clk);
    check_acc("R9 two edges");

    // R8 + R9: back-to-back stream of -128*-128, wraps at 2^24
    for (int half = 0; half < 2; half++) begin
      for (int i = 0; i < 512; i++) begin
        @(negedge clk);
        mode_i = 2'd2; a_i = 16'h8080; b_i = 16'h8080; valid_i = 1'b1;
        clear_i = (half == 0 && i == 0);
        model_op(2'd2, clear_i, 16'h8080, 16'h8080);
      end
      @(negedge clk);
      valid_i = 1'b0; clear_i = 1'b0;
      @(negedge clk);
      check_acc(half == 0 ? "R8 half scale" : "R8 wrap to zero");
    end

    // R1: reset in mid-run
    do_op(2'd0, 1'b1, 16'h5A5A, 16'hC3C3, "R7 before reset");
    @(negedge clk);
    rst_n = 1'b0;
    reset_model();
    @(negedge clk);
    check_acc("R1 mid-run reset");
    rst_n = 1'b1;
    do_op(2'd2, 1'b0, 16'h7F7F, 16'h7F7F, "R1 precision after reset");

    finish_run();
  end

endmodule